// File: doc/BRIEF.md
# Transactional Cache Read/Write Tracker

This block tracks the speculative state of a small direct-mapped data cache owned by one processor in a multiprocessor where every piece of work runs as a transaction. Each cached line carries a valid flag, a tag, a speculative-read flag and a speculative-write flag. Loads set the read flag of the line they touch and stores set the write flag. The first store to a line also records the line address in a commit queue, so each written line appears there once. The tracker keeps no data and no state beyond this, and a miss allocates the line at once. Refill from memory is handled elsewhere.

When the commit arbiter grants this processor the commit right, the tracker walks the commit queue. It places one written line address per cycle on the commit bus, then pulses a completion flag and clears all speculative flags. Meanwhile it watches the addresses that other processors commit. A committed address that matches a line this transaction has read is a true conflict: the tracker raises an abort in that same cycle, drops every line it has written, and clears all flags and the queue. An access that would have to evict a line holding speculative state cannot proceed. The tracker then reports an overflow and holds the access until it is granted the commit right, commits, and lets the access through.

The controller has three states. RUN accepts accesses. OVERFLOW holds a blocked access until the commit grant. DRAIN broadcasts the queue. The transitions are: RUN to DRAIN on a grant (commit start); RUN to OVERFLOW on a blocked eviction (overflow entry); OVERFLOW to DRAIN on a grant (forced commit); DRAIN to RUN when the queue is empty (commit finish); and RUN or OVERFLOW to RUN on a conflict (abort).

Top module: `txrw_tracker`

## Requirements
- R1: After reset, stall, hit, commit bus valid, commit done, abort and overflow are all low, and every line is invalid, so the first access to any address reports a miss.
- R2: A load accepted in RUN sets the line's read flag. A later snoop of the same address raises abort in the snoop cycle. A snoop of a different tag at the same index does not.
- R3: Only a store that finds the write flag clear pushes its address into the commit queue. Repeated stores to a line yield a single broadcast, and broadcasts follow the order of first stores.
- R4: A grant in RUN stalls accesses in that cycle. From the next cycle, one queued address is broadcast per cycle. One cycle after the last broadcast, commit done pulses. With an empty queue, commit done comes in the first cycle after the grant, with no broadcast.
- R5: A snoop that matches a line this transaction has only written, never read, does not abort.
- R6: An abort clears all flags and empties the queue, so a following commit broadcasts nothing. Lines with the write flag become invalid (a later load misses), and lines only read stay valid (a later load hits).
- R7: An access whose index holds a line with a set flag and a different tag stalls. From the next cycle, overflow is high until a grant. The tracker then drains the queue, and after commit done the held access is accepted as a miss.
- R8: After commit done, read flags are clear (a snoop of a previously read address does not abort), and written lines stay valid (a load to one hits).
- R9: A snoop in the same cycle as an accepted load to the same address aborts, and the load's read flag is not kept. A snoop hit in the same cycle as a grant aborts, and no drain starts.
- R10: Hit is high for an access whose index holds a valid line with a matching tag. The address splits into index bits [IDX_W-1:0] and tag bits above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Processor access present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address of the access |
| req_stall | output | 1 | Access not accepted this cycle |
| req_hit | output | 1 | Access index holds a valid line with matching tag |
| commit_grant | input | 1 | Commit right granted by the arbiter |
| commit_done | output | 1 | Pulse: commit finished, flags cleared |
| cbus_valid | output | 1 | Broadcast address present |
| cbus_addr | output | ADDR_W | Written line address being committed |
| snoop_valid | input | 1 | Another processor commits an address |
| snoop_addr | input | ADDR_W | Address committed elsewhere |
| abort | output | 1 | Conflict: local transaction aborted this cycle |
| overflow | output | 1 | Blocked eviction, waiting for commit right |

## Verification
The cases that need care are those where a remote commit and a local event meet in one clock cycle. One is a snoop arriving with a load to the same address. The bench drives both in one cycle, expects abort in that cycle, and then snoops again to confirm that the load left no read flag behind. The other is a snoop hit arriving with the commit grant. The bench drives both together, expects abort, and requires that neither a broadcast nor commit done follows. The scoreboard's queue of expected addresses is empty at that point, so any stray broadcast is reported.

// File: rtl/txrw_pkg.sv
package txrw_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_OVFL  = 2'd1,
        ST_DRAIN = 2'd2
    } txrw_state_e;
endpackage

// File: rtl/txrw_fifo.sv
module txrw_fifo #(
    parameter int ADDR_W = 16,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              clr,
    input  logic [ADDR_W-1:0] din,
    output logic [ADDR_W-1:0] dout,
    output logic              empty,
    output logic              full
);
    localparam int DEPTH = 1 << PTR_W;

    logic [ADDR_W-1:0] mem_q [DEPTH];
    logic [PTR_W:0]    wptr_q, rptr_q;

    assign empty = (wptr_q == rptr_q);
    assign full  = (wptr_q[PTR_W] != rptr_q[PTR_W]) &&
                   (wptr_q[PTR_W-1:0] == rptr_q[PTR_W-1:0]);
    assign dout  = mem_q[rptr_q[PTR_W-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + 1'b1;
            if (pop)  rptr_q <= rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wptr_q[PTR_W-1:0]] <= din;
    end

    // Each line enters the queue once, so the queue never overruns.
    assert_no_fifo_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_fifo_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txrw_lines.sv
module txrw_lines #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             commit_clr,
    input  logic             abort_clr,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [IDX_W-1:0] drn_idx,
    input  logic [TAG_W-1:0] drn_tag,
    output logic             acc_hit,
    output logic             acc_spec,
    output logic             acc_wr_set,
    output logic             snp_rd_hit,
    output logic             drn_wr_hit
);
    localparam int NLINES = 1 << IDX_W;

    logic [NLINES-1:0] valid_q, rd_q, wr_q;
    logic [TAG_W-1:0]  tag_q [NLINES];

    always_comb begin
        acc_hit    = valid_q[acc_idx] && (tag_q[acc_idx] == acc_tag);
        acc_spec   = rd_q[acc_idx] || wr_q[acc_idx];
        acc_wr_set = acc_hit && wr_q[acc_idx];
        snp_rd_hit = valid_q[snp_idx] && rd_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
        drn_wr_hit = valid_q[drn_idx] && wr_q[drn_idx] && (tag_q[drn_idx] == drn_tag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
        end else if (abort_clr) begin
            valid_q <= valid_q & ~wr_q;
            rd_q    <= '0;
            wr_q    <= '0;
        end else if (commit_clr) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (acc_en && (acc_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    if (acc_wr) wr_q[i] <= 1'b1;
                    else        rd_q[i] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc_en) tag_q[acc_idx] <= acc_tag;
    end

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
            assert_wr_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
                wr_q[g] |-> valid_q[g]);
        end
    endgenerate

    assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_clr |=> (rd_q == '0) && (wr_q == '0));
    assert_commit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_clr && !abort_clr |=> (rd_q == '0) && (wr_q == '0));
endmodule

// File: rtl/txrw_tracker.sv
module txrw_tracker #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_stall,
    output logic              req_hit,
    input  logic              commit_grant,
    output logic              commit_done,
    output logic              cbus_valid,
    output logic [ADDR_W-1:0] cbus_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              abort,
    output logic              overflow
);
    import txrw_pkg::*;

    localparam int TAG_W = ADDR_W - IDX_W;

    txrw_state_e state_q, state_d;

    logic              acc_hit, acc_spec, acc_wr_set, snp_rd_hit, drn_wr_hit;
    logic              evict_blk, same_cycle_rd, start_commit, accept, push;
    logic              fifo_pop, fifo_clr, fifo_empty, fifo_full;
    logic [ADDR_W-1:0] fifo_dout;
    logic              commit_clr;

    // Conflict: a remote commit against this transaction's reads.
    always_comb begin
        evict_blk     = req_valid && !acc_hit && acc_spec;
        same_cycle_rd = (state_q == ST_RUN) && req_valid && !req_write &&
                        (req_addr == snoop_addr);
        abort         = (state_q != ST_DRAIN) && snoop_valid && (snp_rd_hit || same_cycle_rd);
        start_commit  = (state_q == ST_RUN) && commit_grant && !abort;
        req_stall     = (state_q != ST_RUN) || evict_blk || start_commit || abort;
        accept        = req_valid && !req_stall;
        push          = accept && req_write && !acc_wr_set;
        req_hit       = acc_hit;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (abort)             state_d = ST_RUN;
                else if (start_commit) state_d = ST_DRAIN;
                else if (evict_blk)    state_d = ST_OVFL;
            end
            ST_OVFL: begin
                if (abort)             state_d = ST_RUN;
                else if (commit_grant) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (fifo_empty)        state_d = ST_RUN;
            end
            default:                   state_d = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        cbus_valid  = 1'b0;
        fifo_pop    = 1'b0;
        commit_done = 1'b0;
        overflow    = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_OVFL:  overflow = 1'b1;
            ST_DRAIN: begin
                fifo_pop    = !fifo_empty;
                cbus_valid  = !fifo_empty && drn_wr_hit;
                commit_done = fifo_empty;
            end
            default:  ;
        endcase
        cbus_addr  = fifo_dout;
        commit_clr = commit_done;
        fifo_clr   = abort || commit_done;
    end

    txrw_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (accept),
        .acc_wr     (req_write),
        .acc_idx    (req_addr[IDX_W-1:0]),
        .acc_tag    (req_addr[ADDR_W-1:IDX_W]),
        .commit_clr (commit_clr),
        .abort_clr  (abort),
        .snp_idx    (snoop_addr[IDX_W-1:0]),
        .snp_tag    (snoop_addr[ADDR_W-1:IDX_W]),
        .drn_idx    (fifo_dout[IDX_W-1:0]),
        .drn_tag    (fifo_dout[ADDR_W-1:IDX_W]),
        .acc_hit    (acc_hit),
        .acc_spec   (acc_spec),
        .acc_wr_set (acc_wr_set),
        .snp_rd_hit (snp_rd_hit),
        .drn_wr_hit (drn_wr_hit)
    );

    txrw_fifo #(.ADDR_W(ADDR_W), .PTR_W(IDX_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (fifo_pop),
        .clr   (fifo_clr),
        .din   (req_addr),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assert_abort_empties_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> fifo_empty);
    assert_bcast_only_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cbus_valid |-> req_stall);
    assert_ovfl_after_blocked_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(req_valid) && !$past(req_hit));
    assert_done_leaves_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> fifo_empty && !overflow && !cbus_valid);
    assert_no_abort_while_draining_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cbus_valid |-> !abort);
endmodule

// File: tb/txrw_tracker_bench.sv
module txrw_tracker_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_stall, req_hit;
    logic          commit_grant = 1'b0, commit_done;
    logic          cbus_valid;
    logic [AW-1:0] cbus_addr;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          abort, overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW-1:0] expq [$];

    always #2.5 clk = ~clk;

    txrw_tracker #(.ADDR_W(AW), .IDX_W(3)) u_txrw_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_stall(req_stall), .req_hit(req_hit),
        .commit_grant(commit_grant), .commit_done(commit_done),
        .cbus_valid(cbus_valid), .cbus_addr(cbus_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .abort(abort), .overflow(overflow));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every broadcast is popped from the expected queue.
    always @(negedge clk) begin
        #1;
        if (rst_n && cbus_valid) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R3/R6 broadcast: actual %0h expected none", cbus_addr);
            end else begin
                chk("R3 broadcast order", cbus_addr, expq.pop_front());
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 0; snoop_valid = 0; commit_grant = 0;
    endtask

    // One accepted access; first_wr marks a store expected in the queue.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic exp_hit,
                          input logic first_wr, input string req);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; snoop_valid = 0; commit_grant = 0;
        #1;
        chk({req, " stall"}, req_stall, 1'b0);
        chk({req, " hit"}, req_hit, exp_hit);
        if (first_wr) expq.push_back(a);
        @(posedge clk);
        #0.5 req_valid = 0;
    endtask

    task automatic snoop(input logic [AW-1:0] a, input logic exp_abort, input string req);
        @(negedge clk);
        snoop_valid = 1; snoop_addr = a; req_valid = 0;
        #1 chk({req, " abort"}, abort, exp_abort);
        if (abort) expq.delete();
        @(posedge clk);
        #0.5 snoop_valid = 0;
    endtask

    task automatic commit(input int nbc, input string req);
        int cyc;
        @(negedge clk);
        commit_grant = 1; req_valid = 0;
        #1 chk({req, " stall at grant"}, req_stall, 1'b1);
        @(posedge clk);
        #0.5 commit_grant = 0;
        cyc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            cyc++;
            if (commit_done) break;
        end
        chk({req, " done cycle"}, cyc, nbc + 1);
        chk({req, " queue drained"}, expq.size(), 0);
    endtask

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 stall", req_stall, 0);
        chk("R1 cbus", cbus_valid, 0);
        chk("R1 done", commit_done, 0);
        chk("R1 abort", abort, 0);
        chk("R1 overflow", overflow, 0);
        rst_n = 1;
        access(0, 16'h0010, 0, 0, "R1 first miss");
        access(0, 16'h0010, 1, 0, "R10 load hit");
        access(1, 16'h0021, 0, 1, "R3 first store");
        access(1, 16'h0021, 1, 0, "R3 repeat store");
        access(1, 16'h0012, 0, 1, "R3 second line");
        snoop(16'h0021, 0, "R5 write-only line");
        snoop(16'h0018, 0, "R2 other tag same index");
        commit(2, "R4 commit two lines");
        snoop(16'h0010, 0, "R8 read flag cleared");
        access(0, 16'h0021, 1, 0, "R8 written line valid");
        access(1, 16'h0044, 0, 1, "R6 store before abort");
        access(0, 16'h0055, 0, 0, "R6 load before abort");
        snoop(16'h0021, 1, "R2 read conflict");
        access(0, 16'h0044, 0, 0, "R6 written line invalid");
        access(0, 16'h0055, 1, 0, "R6 read line kept");
        commit(0, "R6 empty commit after abort");
        // R7 overflow
        access(0, 16'h0016, 0, 0, "R7 setup load");
        access(1, 16'h0027, 0, 1, "R7 setup store");
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 16'h001E;
        #1 chk("R7 blocked stall", req_stall, 1);
        @(negedge clk); #1;
        chk("R7 overflow high", overflow, 1);
        @(negedge clk); #1;
        chk("R7 overflow held", overflow, 1);
        commit_grant = 1;
        @(posedge clk);
        #0.5 commit_grant = 0;
        begin
            int w;
            w = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk); #1;
                if (!req_stall) break;
                w++;
            end
            chk("R7 held access wait", w, 2);
            chk("R7 held access miss", req_hit, 0);
            chk("R7 overflow cleared", overflow, 0);
            chk("R7 queue drained", expq.size(), 0);
        end
        @(posedge clk);
        #0.5 req_valid = 0;
        // R9 same-cycle load and snoop
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 16'h0031;
        snoop_valid = 1; snoop_addr = 16'h0031;
        #1 chk("R9 load+snoop abort", abort, 1);
        @(posedge clk);
        #0.5 begin req_valid = 0; snoop_valid = 0; end
        snoop(16'h0031, 0, "R9 load discarded");
        // R9 grant and snoop hit together
        access(1, 16'h0032, 0, 1, "R9 store before race");
        access(0, 16'h0045, 0, 0, "R9 load before race");
        @(negedge clk);
        commit_grant = 1; snoop_valid = 1; snoop_addr = 16'h0045;
        #1 chk("R9 grant+snoop abort", abort, 1);
        expq.delete();
        @(posedge clk);
        #0.5 begin commit_grant = 0; snoop_valid = 0; end
        @(negedge clk); #1;
        chk("R9 no drain stall", req_stall, 0);
        chk("R9 no commit done", commit_done, 0);
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule